// File: doc/BRIEF.md
# Variable Pulse Width Bus Frame Receiver

This block receives frames on a single-wire bus where information is carried by the width of each pulse rather than by a fixed bit cell. It is fed an already synchronized bus level and a sample tick. It measures how long each active and passive level lasts, removes glitches shorter than the minimum symbol, and sorts each pulse into a short bit, a long bit or a framing symbol. Bits are assembled most significant first into bytes. Each byte is presented with a one-cycle valid strobe, and a CRC-8 runs over the whole frame.

A frame opens with a long active start symbol and closes with a long passive end-of-data symbol. There is no limit on frame length, so block transfers of any size are delivered byte by byte. When the end-of-data symbol arrives, a status code reports whether the frame was good, had a bad CRC, or broke its framing rules. The same code can raise a one-cycle interrupt. A configuration input also lets the receiver accept frames sent at four times the normal bit rate. When that input is low, such traffic is discarded silently.

All widths below are in sample ticks, with the default parameters (one tick per nominal microsecond). The bus input is 1 for the active level and 0 for the passive level.

Top module: `vpw_rx`

## Requirements
- R1: After reset, `status` is 0 (idle), and `rx_valid` and `irq` are 0.
- R2: Inside a frame, a passive pulse of 34..95 ticks or an active pulse of 96..162 ticks decodes as 1. A passive pulse of 96..162 ticks or an active pulse of 34..95 ticks decodes as 0. Bits fill a byte MSB first. Every eighth bit gives a one-cycle `rx_valid` with the byte on `rx_byte` and `status` = 1.
- R3: A frame starts only on an active pulse of 163..238 ticks. While idle, every other pulse is ignored and produces neither bytes nor events.
- R4: A passive level held for 163 ticks inside a frame is end-of-data. At a byte boundary, a CRC-8 register (polynomial 0x1D, preset 0xFF at frame start, shifted MSB first over every received byte including the final CRC byte) that holds 0xC4 gives `status` = 2. The CRC byte is delivered as the last byte.
- R5: End-of-data at a byte boundary with any other CRC register value gives `status` = 3.
- R6: End-of-data arriving when the bit count within the byte is not zero gives `status` = 4.
- R7: Inside a frame, an active pulse of 163 ticks or more is a framing error: `status` = 4, and the frame is dropped. An active level still held at 239 ticks reports this at once.
- R8: Frame length is unbounded, and every byte up to end-of-data is delivered.
- R9: With `rx4x_en` = 1, a frame whose pulse widths are all divided by four (start symbol 40..58 ticks, short/long boundary 24, end-of-data 40) is received under R2 to R7.
- R10: With `rx4x_en` = 0, fourfold-rate traffic produces no bytes and no events.
- R11: A level change lasting less than 34 ticks (8 ticks inside a fourfold-rate frame or while idle with `rx4x_en` = 1) is noise. It is merged into the surrounding pulse.
- R12: Every status event pulses `irq` for one cycle when `irq_en` = 1. When `irq_en` = 0, `irq` stays 0 and `status` still updates.
- R13: Widths are counted in `tick` cycles, and the bus is sampled only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable, one per width unit |
| bus_in | input | 1 | Synchronized bus level, 1 = active |
| rx4x_en | input | 1 | Accept fourfold-rate frames |
| irq_en | input | 1 | Interrupt enable |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| status | output | 3 | 0 idle, 1 byte, 2 end-of-data good, 3 CRC error, 4 framing error |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench first drives frames whose CRC byte is right and then frames whose CRC byte has one bit flipped. A receiver that checked the residue wrongly, or skipped the CRC byte, would return the wrong code for one of the two. It cuts frames off in mid-byte and drives an oversized active pulse inside a frame. A receiver that ignored the bit position, or a missing timeout, would report a good end or hang in the frame. It splits a long passive bit with a short glitch, which a missing noise filter would turn into extra bits. It sends fourfold-rate frames with the enable on and off, runs a 40-byte block frame, and runs a frame with a halved tick rate, where a width counted in clocks rather than ticks would misdecode every bit.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_BYTE  = 3'd1,
      ST_EOD   = 3'd2,
      ST_CRC   = 3'd3,
      ST_FRAME = 3'd4
   } rx_status_e;

   typedef enum logic [2:0] {
      PC_NOISE,
      PC_SHORT,
      PC_LONG,
      PC_SOF,
      PC_OVER
   } pulse_cls_e;

endpackage

// File: rtl/vpw_pulse_meter.sv
// Glitch-filtered level tracker; reports the width of each accepted pulse.
module vpw_pulse_meter #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          bus_in,
   input  logic [CW-1:0] nth,
   output logic          lvl,
   output logic [CW-1:0] cnt,
   output logic          steady,
   output logic          done,
   output logic          done_lvl,
   output logic [CW-1:0] width
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] pend;
   logic [CW-1:0] pend_nx;
   logic [CW-1:0] cnt_inc;

   assign pend_nx = pend + 1'b1;
   assign cnt_inc = (cnt == CMAX) ? cnt : cnt + 1'b1;
   assign steady  = (bus_in == lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl      <= 1'b0;
         cnt      <= '0;
         pend     <= '0;
         done     <= 1'b0;
         done_lvl <= 1'b0;
         width    <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (steady) begin
               pend <= '0;
               cnt  <= cnt_inc;
            end else if (pend_nx >= nth) begin
               done     <= 1'b1;
               done_lvl <= lvl;
               width    <= cnt - pend;
               lvl      <= bus_in;
               cnt      <= pend_nx;
               pend     <= '0;
            end else begin
               pend <= pend_nx;
               cnt  <= cnt_inc;
            end
         end
      end
   end
endmodule

// File: rtl/vpw_pulse_class.sv
// Sorts a measured width into a symbol class against fixed windows.
module vpw_pulse_class
   import vpw_rx_pkg::*;
#(
   parameter int CW   = 9,
   parameter int T_N  = 34,
   parameter int T_SL = 96,
   parameter int T_LS = 163,
   parameter int T_MX = 239
) (
   input  logic [CW-1:0] width,
   output pulse_cls_e    cls
);
   always_comb begin
      if (width < CW'(T_N))       cls = PC_NOISE;
      else if (width < CW'(T_SL)) cls = PC_SHORT;
      else if (width < CW'(T_LS)) cls = PC_LONG;
      else if (width < CW'(T_MX)) cls = PC_SOF;
      else                        cls = PC_OVER;
   end
endmodule

// File: rtl/vpw_crc8.sv
// Bit-serial CRC-8, MSB first.
module vpw_crc8 #(
   parameter logic [7:0] POLY = 8'h1D,
   parameter logic [7:0] INIT = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       bit_in,
   output logic [7:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= INIT;
      else if (clr) crc <= INIT;
      else if (en)  crc <= {crc[6:0], 1'b0} ^ (((crc[7] ^ bit_in) != 1'b0) ? POLY : 8'h00);
   end
endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
   import vpw_rx_pkg::*;
#(
   parameter int         T_NOISE      = 34,
   parameter int         T_SHORT_LONG = 96,
   parameter int         T_LONG_SOF   = 163,
   parameter int         T_SOF_MAX    = 239,
   parameter bit         FAST_EN      = 1'b1,
   parameter logic [7:0] CRC_POLY     = 8'h1D,
   parameter logic [7:0] CRC_INIT     = 8'hFF,
   parameter logic [7:0] CRC_RESIDUE  = 8'hC4,
   parameter int         BYTE_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_in,
   input  logic              rx4x_en,
   input  logic              irq_en,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic [2:0]        status,
   output logic              irq
);
   localparam int CW  = $clog2(T_SOF_MAX + 1) + 1;
   localparam int BCW = $clog2(BYTE_W);
   localparam int F_N  = T_NOISE / 4;
   localparam int F_SL = T_SHORT_LONG / 4;
   localparam int F_LS = T_LONG_SOF / 4;
   localparam int F_MX = T_SOF_MAX / 4;
   localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

   if (!(T_NOISE < T_SHORT_LONG && T_SHORT_LONG < T_LONG_SOF && T_LONG_SOF < T_SOF_MAX))
      begin : g_bad_windows
         $error("vpw_rx: width windows must increase strictly");
      end
   if (FAST_EN && F_N < 1) begin : g_bad_fast
      $error("vpw_rx: noise width too small for fourfold rate");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("vpw_rx: CRC-8 needs 8-bit bytes");
   end

   logic              in_frame, fast;
   logic [BCW-1:0]    bitcnt;
   logic [BYTE_W-2:0] sreg;
   rx_status_e        st_q, ev_code;
   logic              rx4x_ok;
   logic [CW-1:0]     nth, eod_th, max_th;
   logic              lvl, steady, done, done_lvl;
   logic [CW-1:0]     cnt, width;
   logic [CW:0]       cnt_nx;
   pulse_cls_e        cls_n, cls_f, cls;
   logic [7:0]        crc;
   logic is_bit, bit_val, bad_act, start_n, start_f, eod_hit, tmo_hit, stop, ev;

   assign rx4x_ok = FAST_EN && rx4x_en;
   assign nth    = in_frame ? (fast ? CW'(F_N) : CW'(T_NOISE))
                            : (rx4x_ok ? CW'(F_N) : CW'(T_NOISE));
   assign eod_th = fast ? CW'(F_LS) : CW'(T_LONG_SOF);
   assign max_th = fast ? CW'(F_MX) : CW'(T_SOF_MAX);
   assign cnt_nx = {1'b0, cnt} + 1'b1;

   vpw_pulse_meter #(.CW(CW)) u_meter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus_in), .nth(nth),
      .lvl(lvl), .cnt(cnt), .steady(steady), .done(done),
      .done_lvl(done_lvl), .width(width)
   );

   vpw_pulse_class #(.CW(CW), .T_N(T_NOISE), .T_SL(T_SHORT_LONG),
                     .T_LS(T_LONG_SOF), .T_MX(T_SOF_MAX)) u_cls_n (
      .width(width), .cls(cls_n)
   );

   if (FAST_EN) begin : g_fast
      vpw_pulse_class #(.CW(CW), .T_N(F_N), .T_SL(F_SL),
                        .T_LS(F_LS), .T_MX(F_MX)) u_cls_f (
         .width(width), .cls(cls_f)
      );
   end else begin : g_nofast
      assign cls_f = PC_NOISE;
   end

   vpw_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(start_n || start_f), .en(is_bit),
      .bit_in(bit_val), .crc(crc)
   );

   always_comb begin
      cls     = fast ? cls_f : cls_n;
      is_bit  = done && in_frame && (cls == PC_SHORT || cls == PC_LONG);
      bit_val = done_lvl ? (cls == PC_LONG) : (cls == PC_SHORT);
      bad_act = done && in_frame && done_lvl && (cls == PC_SOF || cls == PC_OVER);
      start_n = done && !in_frame && done_lvl && cls_n == PC_SOF;
      start_f = done && !in_frame && done_lvl && rx4x_ok && cls_f == PC_SOF;
      eod_hit = tick && in_frame && !lvl && steady && cnt_nx >= {1'b0, eod_th};
      tmo_hit = tick && in_frame && lvl && steady && cnt_nx >= {1'b0, max_th};
      stop    = eod_hit || tmo_hit || bad_act;
      ev      = 1'b0;
      ev_code = ST_IDLE;
      if (eod_hit) begin
         ev = 1'b1;
         if (bitcnt != '0)              ev_code = ST_FRAME;
         else if (crc == CRC_RESIDUE)   ev_code = ST_EOD;
         else                           ev_code = ST_CRC;
      end else if (tmo_hit || bad_act) begin
         ev      = 1'b1;
         ev_code = ST_FRAME;
      end else if (is_bit && bitcnt == LAST_BIT) begin
         ev      = 1'b1;
         ev_code = ST_BYTE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         fast     <= 1'b0;
         bitcnt   <= '0;
         sreg     <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
         st_q     <= ST_IDLE;
         irq      <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         irq      <= 1'b0;
         if (start_n || start_f) begin
            in_frame <= 1'b1;
            fast     <= start_f;
            bitcnt   <= '0;
         end else if (stop) begin
            in_frame <= 1'b0;
            fast     <= 1'b0;
         end else if (is_bit) begin
            bitcnt <= bitcnt + 1'b1;
            sreg   <= {sreg[BYTE_W-3:0], bit_val};
            if (bitcnt == LAST_BIT) begin
               rx_byte  <= {sreg, bit_val};
               rx_valid <= 1'b1;
            end
         end
         if (ev) begin
            st_q <= ev_code;
            irq  <= irq_en;
         end
      end
   end

   assign status = st_q;
endmodule

// File: rtl/vpw_rx_chk.sv
module vpw_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic [2:0] status,
   input logic       irq,
   input logic       irq_en,
   input logic       rx4x_en,
   input logic       in_frame,
   input logic       fast,
   input logic [2:0] bitcnt
);
   // R2: a delivered byte carries the byte-received code
   a_r2_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> status == 3'd1);

   // R2: the byte strobe lasts one cycle
   a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R12: interrupt only when enabled
   a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(irq_en));

   // R12: interrupt is a single-cycle pulse
   a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10: fourfold-rate frames start only with the enable set
   a_r10_fast_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(in_frame) && fast) |-> $past(rx4x_en));

   // R6: a good end-of-data only at a byte boundary
   a_r6_eod_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(in_frame) && status == 3'd2) |-> $past(bitcnt) == 3'd0);
endmodule

bind vpw_rx vpw_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .status(status),
   .irq(irq), .irq_en(irq_en), .rx4x_en(rx4x_en), .in_frame(in_frame),
   .fast(fast), .bitcnt(bitcnt)
);

// File: tb/sim_vpw_rx.sv
`timescale 1ns/1ps
module sim_vpw_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_in = 1'b0;
   logic       rx4x_en = 1'b0;
   logic       irq_en = 1'b1;
   logic [7:0] rx_byte;
   logic       rx_valid;
   logic [2:0] status;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   int tdiv   = 1;
   int tph    = 0;
   bit fastm  = 1'b0;

   logic [7:0] tx [0:63];
   logic [7:0] got [0:63];
   logic [7:0] sent_crc;
   int ng = 0;
   int nev = 0;
   int last_code = 0;

   always #10 clk = ~clk;

   vpw_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus_in),
      .rx4x_en(rx4x_en), .irq_en(irq_en), .rx_byte(rx_byte),
      .rx_valid(rx_valid), .status(status), .irq(irq)
   );

   always @(negedge clk) begin
      if (tph >= tdiv - 1) begin
         tph = 0;
         tick <= 1'b1;
      end else begin
         tph = tph + 1;
         tick <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rx_valid) begin
         if (ng < 64) got[ng] = rx_byte;
         ng = ng + 1;
      end
      if (irq) begin
         nev = nev + 1;
         last_code = int'(status);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic sym(input bit lv, input int us);
      int t;
      t = fastm ? us / 4 : us;
      bus_in = lv;
      repeat (t * tdiv) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nb, inout bit gl);
      for (int k = 0; k < nb; k++) begin
         bit bv;
         int w;
         bv = b[7 - k];
         if (k % 2 == 0) begin
            w = bv ? 64 : 128;
            if (gl && w == 128) begin
               sym(1'b0, 60); sym(1'b1, 10); sym(1'b0, 58);
               gl = 1'b0;
            end else sym(1'b0, w);
         end else begin
            w = bv ? 128 : 64;
            sym(1'b1, w);
         end
      end
   endtask

   function automatic logic [7:0] crc_of(input int n);
      logic [7:0] c;
      c = 8'hFF;
      for (int i = 0; i < n; i++)
         for (int b = 7; b >= 0; b--) begin
            bit fb;
            fb = c[7] ^ tx[i][b];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h1D;
         end
      return ~c;
   endfunction

   // mode 0 good, 1 bad CRC, 2 cut mid-byte, 3 oversized active pulse
   task automatic send_frame(input int n, input int mode, input bit glitch);
      bit gl;
      gl = glitch;
      sent_crc = crc_of(n);
      if (mode == 1) sent_crc = sent_crc ^ 8'h01;
      ng = 0; nev = 0; last_code = 0;
      sym(1'b1, 200);
      for (int i = 0; i < n; i++) send_bits(tx[i], 8, gl);
      case (mode)
         0, 1: send_bits(sent_crc, 8, gl);
         2:    send_bits(tx[n], 4, gl);
         default: begin
            send_bits(8'h00, 1, gl);
            sym(1'b1, 300);
         end
      endcase
      sym(1'b0, 200);
      sym(1'b0, 300);
   endtask

   task automatic expect_frame(input string tag, input int n, input int nbytes, input int code);
      int bad;
      bad = 0;
      chk({tag, " byte count"}, ng, nbytes);
      for (int i = 0; i < n && i < ng; i++) if (got[i] !== tx[i]) bad++;
      if (nbytes == n + 1 && ng == n + 1 && got[n] !== sent_crc) bad++;
      chk({tag, " byte values"}, bad, 0);
      chk({tag, " end code"}, last_code, code);
   endtask

   task automatic t_reset;
      chk("R1 status", int'(status), 0);
      chk("R1 rx_valid", int'(rx_valid), 0);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_basic;
      tx[0] = 8'h12; tx[1] = 8'hA5; tx[2] = 8'hFF;
      send_frame(3, 0, 1'b0);
      expect_frame("R2 R4 good frame", 3, 4, 2);
      chk("R12 irq per event", nev, 5);
   endtask

   task automatic t_idle_noise;
      ng = 0; nev = 0;
      sym(1'b1, 120); sym(1'b0, 300); sym(1'b1, 300); sym(1'b0, 300);
      chk("R3 idle pulses bytes", ng, 0);
      chk("R3 idle pulses events", nev, 0);
   endtask

   task automatic t_bad_crc;
      tx[0] = 8'h00; tx[1] = 8'h3C;
      send_frame(2, 1, 1'b0);
      expect_frame("R5 bad crc", 2, 3, 3);
   endtask

   task automatic t_partial;
      tx[0] = 8'h5A; tx[1] = 8'hC3;
      send_frame(1, 2, 1'b0);
      expect_frame("R6 mid-byte eod", 1, 1, 4);
   endtask

   task automatic t_oversize;
      tx[0] = 8'h81;
      send_frame(1, 3, 1'b0);
      expect_frame("R7 long active", 1, 1, 4);
   endtask

   task automatic t_block;
      for (int i = 0; i < 40; i++) tx[i] = 8'((i * 37 + 11) & 8'hFF);
      send_frame(40, 0, 1'b0);
      expect_frame("R8 block frame", 40, 41, 2);
   endtask

   task automatic t_glitch;
      tx[0] = 8'h7F; tx[1] = 8'h01;
      send_frame(2, 0, 1'b1);
      expect_frame("R11 glitch merged", 2, 3, 2);
   endtask

   task automatic t_fast_on;
      rx4x_en = 1'b1;
      fastm = 1'b1;
      tx[0] = 8'hE7; tx[1] = 8'h42; tx[2] = 8'h99;
      send_frame(3, 0, 1'b0);
      expect_frame("R9 fourfold frame", 3, 4, 2);
      fastm = 1'b0;
      tx[0] = 8'h0F;
      send_frame(1, 0, 1'b0);
      expect_frame("R9 normal frame with 4x on", 1, 2, 2);
   endtask

   task automatic t_fast_off;
      rx4x_en = 1'b0;
      fastm = 1'b1;
      tx[0] = 8'hE7; tx[1] = 8'h42; tx[2] = 8'h99;
      send_frame(3, 0, 1'b0);
      fastm = 1'b0;
      chk("R10 4x disabled bytes", ng, 0);
      chk("R10 4x disabled events", nev, 0);
   endtask

   task automatic t_irq_off;
      irq_en = 1'b0;
      tx[0] = 8'h33;
      send_frame(1, 0, 1'b0);
      chk("R12 no irq when disabled", nev, 0);
      chk("R12 status still set", int'(status), 2);
      chk("R12 bytes still delivered", ng, 2);
      irq_en = 1'b1;
   endtask

   task automatic t_tick_div;
      tdiv = 2;
      tx[0] = 8'hB6; tx[1] = 8'h6D;
      send_frame(2, 0, 1'b0);
      expect_frame("R13 halved tick rate", 2, 3, 2);
      tdiv = 1;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      sym(1'b0, 300);
      t_basic();
      t_idle_noise();
      t_bad_crc();
      t_partial();
      t_oversize();
      t_glitch();
      t_fast_on();
      t_fast_off();
      t_irq_off();
      t_tick_div();
      t_block();
      summary();
   end
endmodule